// File: doc/BRIEF.md
# VLIW Execute Packet Dispatcher

This block sits between instruction fetch and the issue stage of a very-long-instruction-word core. Fetch hands it one 256-bit fetch packet at a time. The fetch packet holds eight 32-bit instruction slots. The dispatcher keeps a private copy of that packet and cuts it into execute packets, using a chaining bit carried in every instruction word. It issues one execute packet per clock on eight issue lanes.

Issued words are packed from lane 0 upwards. Each lane carries its instruction word, a valid bit and the slot number the word came from. An execute packet never runs past slot 7, so a packet always closes at the fetch boundary. Fetch sees a ready signal that stays low while slots of the held packet remain to be issued. A redirect (flush) throws away whatever is left of the held packet.

Top module: `vliw_issue_splitter`

## Requirements
- R1: A fetch packet is accepted on a clock edge where `fp_valid` and `fp_ready` are both 1. On the next cycle its first execute packet is on the lanes, starting with slot 0 in lane 0. Slot k occupies `fp_data[32*k+31:32*k]`.
- R2: The chaining bit is bit 0 of each instruction word. A 1 in slot k puts slot k+1 in the same execute packet. A 0 ends the execute packet at slot k.
- R3: Slot 7 always ends an execute packet, whatever its own chaining bit holds. An execute packet therefore never spans two fetch packets and never exceeds eight instructions.
- R4: Lane j carries the slot `start+j`, where `start` is the first slot of the packet. The lane's word is on `ep_lane_word[32*j+31:32*j]`, its 3-bit slot number on `ep_lane_slot[3*j+2:3*j]`, and `ep_lane_valid[j]` is 1. Lanes outside the packet read valid 0, word 0 and slot 0. The valid lanes are always a contiguous run from lane 0.
- R5: One execute packet issues per cycle with `ep_valid` high. Each following packet starts at the slot after the previous packet's last slot.
- R6: While a fetch packet is held and the packet being issued is not its last, `fp_ready` is 0. When nothing is held, or the last packet is issuing and there is no flush, `fp_ready` is 1. This allows a new fetch packet to be taken with no bubble.
- R7: `ep_last` is 1 exactly when the issuing execute packet ends at slot 7.
- R8: In a cycle with `flush` high, `ep_valid` and `fp_ready` are both 0 and no fetch packet is accepted. The unissued slots are discarded, so the next cycle shows no execute packet and `fp_ready` is 1.
- R9: Synchronous reset (`rst` high at a clock edge) leaves no packet held. After it, `ep_valid` is 0, all lane valids are 0 and `fp_ready` is 1.
- R10: A fetch packet whose chaining bits are all 1 issues as a single eight-wide packet ending at slot 7. One whose chaining bits are all 0 issues as eight single-slot packets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| fp_valid | input | 1 | Fetch offers a fetch packet |
| fp_data | input | 256 | Fetch packet, slot k in bits 32k+31..32k |
| fp_ready | output | 1 | Dispatcher can take a fetch packet this cycle |
| flush | input | 1 | Redirect: discard the rest of the held fetch packet |
| ep_valid | output | 1 | An execute packet is issuing this cycle |
| ep_last | output | 1 | The issuing execute packet ends at slot 7 |
| ep_lane_valid | output | 8 | Per-lane valid, contiguous from lane 0 |
| ep_lane_word | output | 256 | Per-lane instruction word, lane j in bits 32j+31..32j |
| ep_lane_slot | output | 24 | Per-lane source slot number, lane j in bits 3j+2..3j |

## Verification
The bench runs chaining patterns through a reference splitter. The all-ones pattern tests the forced close at slot 7, because a design that follows bit 0 of slot 7 would run past the fetch boundary or never drop its held packet. The all-zeros pattern has to yield eight single-slot packets; a pointer that fails to advance shows up there as a stuck or repeated slot number. A new fetch packet is offered during the cycle its predecessor's last packet issues; a design without that early ready loses a cycle or drops the new data. Flushes are placed mid-packet and together with an offered fetch packet, to catch a design that keeps issuing stale slots or takes a packet while flushing.

// File: rtl/vlx_pkg.sv
package vlx_pkg;

    // Default geometry of a fetch packet.
    localparam int unsigned SLOTS    = 8;
    localparam int unsigned WORD_W   = 32;
    // Bit inside each word that chains it to the following slot.
    localparam int unsigned CHAIN_BIT = 0;

    // Mask with the low n bits set, n in 0..SLOTS.
    function automatic logic [SLOTS-1:0] low_mask(input int unsigned n);
        logic [SLOTS-1:0] m;
        m = '0;
        for (int unsigned i = 0; i < SLOTS; i++) begin
            if (i < n) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/vlx_ep_boundary.sv
// Finds where the execute packet that begins at 'start' ends.
module vlx_ep_boundary #(
    parameter int unsigned NSLOT = 8,
    localparam int unsigned SW   = $clog2(NSLOT)
) (
    input  logic [NSLOT-1:0] chain,
    input  logic [SW-1:0]    start,
    output logic [SW-1:0]    stop,
    output logic [SW:0]      count
);

    localparam logic [SW-1:0] LAST = SW'(NSLOT - 1);

    always_comb begin
        // The final slot closes the packet unconditionally.
        stop = LAST;
        // Scanning downwards leaves the lowest open link at or above start.
        for (int s = int'(NSLOT) - 2; s >= 0; s--) begin
            if (s >= int'(start) && !chain[s]) begin
                stop = SW'(s);
            end
        end
        count = (SW+1)'(stop) - (SW+1)'(start) + (SW+1)'(1);
    end

endmodule

// File: rtl/vlx_lane_pack.sv
// Moves the selected slots onto issue lanes, packed from lane 0.
module vlx_lane_pack #(
    parameter int unsigned NSLOT  = 8,
    parameter int unsigned WORD_W = 32,
    localparam int unsigned SW    = $clog2(NSLOT)
) (
    input  logic [NSLOT*WORD_W-1:0] pkt,
    input  logic [SW-1:0]           start,
    input  logic [SW:0]             count,
    input  logic                    enable,
    output logic [NSLOT-1:0]        lane_vld,
    output logic [NSLOT*WORD_W-1:0] lane_word,
    output logic [NSLOT*SW-1:0]     lane_slot
);

    for (genvar j = 0; j < NSLOT; j++) begin : g_lane
        logic [SW-1:0] idx;
        logic          on;

        assign idx = start + SW'(j);
        assign on  = enable && ((SW+1)'(j) < count);

        assign lane_vld[j]                   = on;
        assign lane_word[j*WORD_W +: WORD_W] = on ? pkt[idx*WORD_W +: WORD_W] : '0;
        assign lane_slot[j*SW +: SW]         = on ? idx : '0;
    end

endmodule

// File: rtl/vliw_issue_splitter.sv
module vliw_issue_splitter #(
    parameter int unsigned NSLOT     = vlx_pkg::SLOTS,
    parameter int unsigned WORD_W    = vlx_pkg::WORD_W,
    parameter int unsigned CHAIN_BIT = vlx_pkg::CHAIN_BIT,
    localparam int unsigned SW       = $clog2(NSLOT),
    localparam int unsigned PKT_W    = NSLOT * WORD_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               fp_valid,
    input  logic [PKT_W-1:0]   fp_data,
    output logic               fp_ready,
    input  logic               flush,
    output logic               ep_valid,
    output logic               ep_last,
    output logic [NSLOT-1:0]   ep_lane_valid,
    output logic [PKT_W-1:0]   ep_lane_word,
    output logic [NSLOT*SW-1:0] ep_lane_slot
);

    localparam logic [SW-1:0] LAST = SW'(NSLOT - 1);

    typedef struct packed {
        logic             held;
        logic [SW-1:0]    ptr;
        logic [PKT_W-1:0] pkt;
    } disp_state_t;

    disp_state_t st_q, st_d;

    logic [NSLOT-1:0] chain;
    logic [SW-1:0]    stop;
    logic [SW:0]      count;
    logic             take;

    for (genvar s = 0; s < NSLOT; s++) begin : g_chain
        assign chain[s] = st_q.pkt[s*WORD_W + CHAIN_BIT];
    end

    vlx_ep_boundary #(.NSLOT(NSLOT)) u_bound (
        .chain (chain),
        .start (st_q.ptr),
        .stop  (stop),
        .count (count)
    );

    vlx_lane_pack #(.NSLOT(NSLOT), .WORD_W(WORD_W)) u_pack (
        .pkt       (st_q.pkt),
        .start     (st_q.ptr),
        .count     (count),
        .enable    (ep_valid),
        .lane_vld  (ep_lane_valid),
        .lane_word (ep_lane_word),
        .lane_slot (ep_lane_slot)
    );

    always_comb begin
        st_d     = st_q;
        ep_valid = st_q.held && !flush;
        ep_last  = ep_valid && (stop == LAST);
        fp_ready = (!st_q.held || ep_last) && !flush;
        take     = fp_valid && fp_ready;

        if (flush) begin
            st_d.held = 1'b0;
            st_d.ptr  = '0;
        end else if (ep_valid) begin
            if (stop == LAST) begin
                st_d.held = 1'b0;
                st_d.ptr  = '0;
            end else begin
                st_d.ptr  = stop + SW'(1);
            end
        end

        if (take) begin
            st_d.held = 1'b1;
            st_d.ptr  = '0;
            st_d.pkt  = fp_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    // Checks kept beside the logic they watch.
    AST_FIRST_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
        ($past(take) && !$past(rst) && !flush) |-> (ep_valid && ep_lane_slot[SW-1:0] == '0)); // R1

    AST_LANES_CONTIG: assert property (@(posedge clk) disable iff (rst)
        ep_valid |-> (((NSLOT'(ep_lane_valid + 1'b1)) & ep_lane_valid) == '0 && ep_lane_valid[0])); // R4

    AST_IDLE_LANES: assert property (@(posedge clk) disable iff (rst)
        !ep_valid |-> (ep_lane_valid == '0)); // R4

    AST_NEXT_START: assert property (@(posedge clk) disable iff (rst)
        (ep_valid && !ep_last) |=> (flush || (ep_valid && ep_lane_slot[SW-1:0] == SW'($past(stop) + 1'b1)))); // R5

    AST_READY_HELD: assert property (@(posedge clk) disable iff (rst)
        (ep_valid && !ep_last) |-> !fp_ready); // R6

    AST_LAST_FULL: assert property (@(posedge clk) disable iff (rst)
        ep_last |-> ep_lane_valid[NSLOT - 1 - 32'(ep_lane_slot[SW-1:0])]); // R3

    AST_FLUSH_DROP: assert property (@(posedge clk) disable iff (rst)
        flush |-> (!fp_ready && !ep_valid)); // R8

    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (rst)
        flush |=> !ep_valid); // R8

endmodule

// File: tb/vliw_issue_splitter_tb.sv
module vliw_issue_splitter_tb;

    logic         clk = 1'b0;
    logic         rst;
    logic         fp_valid;
    logic [255:0] fp_data;
    logic         fp_ready;
    logic         flush;
    logic         ep_valid;
    logic         ep_last;
    logic [7:0]   ep_lane_valid;
    logic [255:0] ep_lane_word;
    logic [23:0]  ep_lane_slot;

    always #5 clk = ~clk;

    vliw_issue_splitter u_dut (
        .clk           (clk),
        .rst           (rst),
        .fp_valid      (fp_valid),
        .fp_data       (fp_data),
        .fp_ready      (fp_ready),
        .flush         (flush),
        .ep_valid      (ep_valid),
        .ep_last       (ep_last),
        .ep_lane_valid (ep_lane_valid),
        .ep_lane_word  (ep_lane_word),
        .ep_lane_slot  (ep_lane_slot)
    );

    // Stimulus table: chaining pattern and the number of execute packets it yields.
    localparam logic [7:0] PATS [10] = '{8'hFF, 8'h00, 8'hAA, 8'h55, 8'h7F,
                                         8'h80, 8'h0F, 8'hF0, 8'h81, 8'h3C};
    localparam int         NPKT [10] = '{1, 8, 5, 4, 1, 8, 4, 5, 7, 4};

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [255:0] act,
                       input logic [255:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [255:0] mk_pkt(input logic [7:0] p, input int tag);
        logic [255:0] v;
        for (int k = 0; k < 8; k++) begin
            v[k*32 +: 32] = {8'(tag), 8'(k), 15'(15'h1234 ^ 15'(tag * 7 + k)), p[k]};
        end
        return v;
    endfunction

    // Checks the lanes for one execute packet covering slots s..e of pkt.
    task automatic chk_packet(input logic [255:0] pkt, input int s, input int e, input string tag);
        logic [255:0] xw;
        logic [23:0]  xs;
        logic [7:0]   xv;
        xw = '0; xs = '0; xv = '0;
        for (int j = 0; j <= e - s; j++) begin
            xw[j*32 +: 32] = pkt[(s+j)*32 +: 32];
            xs[j*3 +: 3]   = 3'(s + j);
            xv[j]          = 1'b1;
        end
        chk(ep_valid == 1'b1, {tag, " R5 ep_valid"}, 256'(ep_valid), 256'(1));
        chk(ep_lane_valid == xv, {tag, (e == 7) ? " R3 lane mask" : " R2 lane mask"},
            256'(ep_lane_valid), 256'(xv));
        chk(ep_lane_word == xw, {tag, " R4 lane words"}, ep_lane_word, xw);
        chk(ep_lane_slot == xs, {tag, " R4 lane slots"}, 256'(ep_lane_slot), 256'(xs));
        chk(ep_last == (e == 7), {tag, " R7 ep_last"}, 256'(ep_last), 256'(e == 7));
        chk(fp_ready == (e == 7), {tag, " R6 fp_ready"}, 256'(fp_ready), 256'(e == 7));
    endtask

    // Offers one fetch packet, then follows every execute packet it yields.
    task automatic run_pkt(input logic [7:0] p, input int tag, output int npk);
        logic [255:0] pkt;
        int s, e;
        pkt = mk_pkt(p, tag);
        npk = 0;
        @(negedge clk);
        fp_valid = 1'b1;
        fp_data  = pkt;
        #1 chk(fp_ready == 1'b1, "R6 ready when idle", 256'(fp_ready), 256'(1));
        @(negedge clk);
        fp_valid = 1'b0;
        s = 0;
        while (s < 8) begin
            e = s;
            while (e < 7 && p[e]) e++;
            #1 chk_packet(pkt, s, e, "R1/R2");
            npk++;
            s = e + 1;
            if (s < 8) @(negedge clk);
        end
        @(negedge clk);
        #1 chk(ep_valid == 1'b0, "R5 no issue after last", 256'(ep_valid), 256'(0));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [255:0] pa, pb;
        int np;
        rst = 1'b1; fp_valid = 1'b0; fp_data = '0; flush = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        chk(ep_valid == 1'b0, "R9 reset ep_valid", 256'(ep_valid), 256'(0));
        chk(ep_lane_valid == 8'h00, "R9 reset lanes", 256'(ep_lane_valid), 256'(0));
        chk(fp_ready == 1'b1, "R9 reset fp_ready", 256'(fp_ready), 256'(1));
        @(negedge clk) rst = 1'b0;

        // Table walk.
        for (int i = 0; i < 10; i++) begin
            run_pkt(PATS[i], i + 1, np);
            chk(np == NPKT[i], (PATS[i] == 8'hFF || PATS[i] == 8'h00) ? "R10 packet count" : "R2 packet count",
                256'(np), 256'(NPKT[i]));
        end

        // Random chaining patterns against the model.
        for (int i = 0; i < 16; i++) begin
            run_pkt(8'($urandom), 40 + i, np);
        end

        // R6/R1: back-to-back accept while the last packet issues.
        pa = mk_pkt(8'hFF, 90);
        pb = mk_pkt(8'h00, 91);
        @(negedge clk); fp_valid = 1'b1; fp_data = pa;
        @(negedge clk); fp_data = pb;
        #1 chk_packet(pa, 0, 7, "R10 all-ones");
        @(negedge clk); fp_valid = 1'b0;
        #1 chk_packet(pb, 0, 0, "R1 back-to-back");

        // R8: flush mid-packet, with a fetch packet offered during the flush.
        @(negedge clk);
        #1 chk_packet(pb, 1, 1, "R5 second slot");
        @(negedge clk); flush = 1'b1; fp_valid = 1'b1; fp_data = pa;
        #1;
        chk(ep_valid == 1'b0, "R8 flush ep_valid", 256'(ep_valid), 256'(0));
        chk(fp_ready == 1'b0, "R8 flush fp_ready", 256'(fp_ready), 256'(0));
        @(negedge clk); flush = 1'b0; fp_valid = 1'b0;
        #1;
        chk(ep_valid == 1'b0, "R8 after flush ep_valid", 256'(ep_valid), 256'(0));
        chk(ep_lane_valid == 8'h00, "R8 after flush lanes", 256'(ep_lane_valid), 256'(0));
        chk(fp_ready == 1'b1, "R8 after flush fp_ready", 256'(fp_ready), 256'(1));

        // R9: reset while a fetch packet is held.
        @(negedge clk); fp_valid = 1'b1; fp_data = pb;
        @(negedge clk); fp_valid = 1'b0; rst = 1'b1;
        #1 chk(ep_valid == 1'b1, "R1 held before reset", 256'(ep_valid), 256'(1));
        @(negedge clk); rst = 1'b0;
        #1;
        chk(ep_valid == 1'b0, "R9 reset drops packet", 256'(ep_valid), 256'(0));
        chk(fp_ready == 1'b1, "R9 ready after reset", 256'(fp_ready), 256'(1));

        // R10: all-zeros once more after the reset.
        run_pkt(8'h00, 99, np);
        chk(np == 8, "R10 all-zeros count", 256'(np), 256'(8));

        finish_run();
    end

endmodule